// File: doc/BRIEF.md
# Radio Codeword Checksum Encoder/Checker

This block is a bit-serial error-check engine for 64-bit control codewords. A codeword carries 48 message bits followed by a 16-bit check field: 15 bits from a cyclic code over the generator x^15 + x^14 + x^13 + x^11 + x^4 + x^2 + 1 (modulo-2 division), with the last of those 15 bits inverted, and then one overall even-parity bit. Bits are offered one per cycle on a serial input, qualified by a valid strobe. Gaps between valid bits are allowed.

In generate mode the block absorbs 48 message bits and returns the 16-bit check field. In check mode it absorbs a whole 64-bit received codeword and reports pass or fail, together with a 16-bit syndrome made of the 15 bits left in the divider plus a parity-error flag. The syndrome is only reported. It is never used to repair bits. A synchronous start/clear input readies the engine for a new codeword and latches the mode for that codeword.

Top module: `cwchk_top`

## Requirements
- R1: In generate mode, after 48 message bits, checkWord[15:1] holds the 15-bit remainder of the message polynomial times x^15 divided by the generator (checkWord[15] is the x^14 coefficient), with checkWord[1] (the x^0 coefficient) inverted. Codeword bit 1 = message bit 1 is the first bit presented, and checkWord[15] is codeword bit 49.
- R2: In generate mode, checkWord[0] is the even-parity bit over the 48 message bits and checkWord[15:1], so that all 64 codeword bits XOR to zero.
- R3: In check mode, the first 63 received bits are divided by the generator with bit 63 inverted before it enters the divider. syndrome[14:0] holds the remaining 15 bits, with syndrome[14] as the x^14 coefficient.
- R4: In check mode, syndrome[15] is 1 when the even parity of received bits 1..63 differs from received bit 64. ok is 1 exactly when all 16 syndrome bits are zero, and a codeword built per R1/R2 gives ok=1 and syndrome 0.
- R5: Flipping any single bit of a valid codeword gives ok=0 and a nonzero syndrome.
- R6: done is high for exactly one cycle, in the cycle after the 48th (generate) or 64th (check) accepted bit. checkWord, syndrome and ok hold their values until the next clear.
- R7: startClr is synchronous. On that edge it zeroes the bit count, the divider, the parity, checkWord, syndrome, ok and done. A bitValid in the same cycle is dropped.
- R8: Bits offered after the final bit of a codeword and before the next clear are ignored: done stays low and the outputs do not change.
- R9: The mode (modeCheck: 0 = generate, 1 = check) is latched only when startClr is high. Changes to modeCheck at other times have no effect on the current codeword.
- R10: After reset, checkWord, syndrome, ok and done are zero and the mode is generate, so a message can be encoded without a prior clear.
- R11: In generate mode, ok stays 0 and syndrome stays 0.
- R12: Cycles with bitValid low neither advance the bit count nor touch the divider, so the result does not depend on gaps in the bit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startClr | input | 1 | Clear engine and latch mode for a new codeword |
| modeCheck | input | 1 | Mode select: 0 generate, 1 check (latched at startClr) |
| bitValid | input | 1 | Qualifies bitIn for this cycle |
| bitIn | input | 1 | Serial codeword bit, codeword bit 1 first |
| checkWord | output | 16 | Generated check field, bit 15 first on the line |
| syndrome | output | 16 | Check-mode syndrome: [14:0] remainder, [15] parity error |
| done | output | 1 | One-cycle pulse when a codeword finishes |
| ok | output | 1 | Check-mode pass flag |

## Verification
The assertions check on every cycle that done never lasts two cycles, that clear leaves the count at zero with done low, that the latched mode changes only at a clear, that the bit count never passes the frame length of the current mode, and that ok, syndrome and checkWord stay consistent and hold steady between captures. The arithmetic itself can only be shown by the bench's scenarios. These scenarios cover encoding of table and random messages against an independent long-division model, acceptance of the resulting codewords, rejection of every single-bit flip, gapped bit streams, and the handling of clear, mode and extra-bit stimulus at the frame edges.

// File: rtl/cwchk_pkg.sv
package cwchk_pkg;
  localparam int REM_W     = 15;
  localparam int MSG_BITS  = 48;
  localparam int CODE_BITS = 64;
  localparam int CHK_W     = REM_W + 1;
  localparam int CNT_W     = $clog2(CODE_BITS + 1);
  // generator without its x^15 term: x^14 x^13 x^11 x^4 x^2 x^0
  localparam logic [REM_W-1:0] GEN_POLY = 15'h6815;

  typedef struct packed {
    logic clear;    // synchronous restart
    logic modeChk;  // latched mode, 1 = check
    logic divEn;    // bit enters divider and parity
    logic invBit;   // invert bit before divider (bit 63 in check mode)
    logic capture;  // final bit of codeword this cycle
  } strobe_t;
endpackage

// File: rtl/cwchk_ctrl.sv
module cwchk_ctrl
  import cwchk_pkg::*;
#(
  parameter int MsgBits  = MSG_BITS,
  parameter int CodeBits = CODE_BITS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startClr,
  input  logic    modeCheck,
  input  logic    bitValid,
  output strobe_t strb,
  output logic    done
);
  localparam int CW = $clog2(CodeBits + 1);
  localparam logic [CW-1:0] GenLen  = CW'(MsgBits);
  localparam logic [CW-1:0] ChkLen  = CW'(CodeBits);
  localparam logic [CW-1:0] ChkDiv  = CW'(CodeBits - 1);
  localparam logic [CW-1:0] InvIdx  = CW'(CodeBits - 2);

  logic [CW-1:0] cnt;
  logic          modeReg;
  logic [CW-1:0] frameLen;
  logic [CW-1:0] divLen;
  logic          accept;

  always_comb begin
    frameLen     = modeReg ? ChkLen : GenLen;
    divLen       = modeReg ? ChkDiv : GenLen;
    accept       = bitValid && !startClr && (cnt < frameLen);
    strb.clear   = startClr;
    strb.modeChk = modeReg;
    strb.divEn   = accept && (cnt < divLen);
    strb.invBit  = accept && modeReg && (cnt == InvIdx);
    strb.capture = accept && (cnt == frameLen - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      modeReg <= 1'b0;
      done    <= 1'b0;
    end else if (startClr) begin
      cnt     <= '0;
      modeReg <= modeCheck;
      done    <= 1'b0;
    end else begin
      done <= strb.capture;
      if (accept) cnt <= cnt + 1'b1;
    end
  end

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: clear restarts the count and silences done
  a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rstN)
    startClr |=> (cnt == '0) && !done);

  // R9: mode only moves on a clear
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    !startClr |=> $stable(modeReg));

  // R8: count never runs past the current frame length
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (cnt <= ChkLen) && (modeReg || (cnt <= GenLen)));
endmodule

// File: rtl/cwchk_dp.sv
module cwchk_dp
  import cwchk_pkg::*;
#(
  parameter int               RemW = REM_W,
  parameter logic [RemW-1:0]  Poly = GEN_POLY
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic          bitIn,
  output logic [RemW:0] checkWord,
  output logic [RemW:0] syndrome,
  output logic          ok
);
  logic [RemW-1:0] rem;
  logic            par;
  logic            din;
  logic            fb;
  logic [RemW-1:0] remStep;
  logic [RemW-1:0] remNext;
  logic            parNext;
  logic [RemW-1:0] chkBits;
  logic            genParity;
  logic            parErr;

  always_comb begin
    din       = bitIn ^ strb.invBit;
    fb        = din ^ rem[RemW-1];
    remStep   = {rem[RemW-2:0], 1'b0} ^ (fb ? Poly : '0);
    remNext   = strb.divEn ? remStep : rem;
    parNext   = strb.divEn ? (par ^ bitIn) : par;
    chkBits   = {remNext[RemW-1:1], ~remNext[0]};
    genParity = parNext ^ (^chkBits);
    parErr    = par ^ bitIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      rem       <= '0;
      par       <= 1'b0;
      checkWord <= '0;
      syndrome  <= '0;
      ok        <= 1'b0;
    end else begin
      rem <= remNext;
      par <= parNext;
      if (strb.capture) begin
        if (strb.modeChk) begin
          checkWord <= '0;
          syndrome  <= {parErr, remNext};
          ok        <= (remNext == '0) && !parErr;
        end else begin
          checkWord <= {chkBits, genParity};
          syndrome  <= '0;
          ok        <= 1'b0;
        end
      end
    end
  end

  // R4: a pass always comes with an all-zero syndrome
  a_r4_ok_zero_syn: assert property (@(posedge clk) disable iff (!rstN)
    ok |-> (syndrome == '0));

  // R11: a generated check field never coexists with check results
  a_r11_gen_clean: assert property (@(posedge clk) disable iff (!rstN)
    (checkWord != '0) |-> ((syndrome == '0) && !ok));

  // R6: results hold between captures
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.clear) |=>
      ($stable(checkWord) && $stable(syndrome) && $stable(ok)));
endmodule

// File: rtl/cwchk_top.sv
module cwchk_top
  import cwchk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startClr,
  input  logic             modeCheck,
  input  logic             bitValid,
  input  logic             bitIn,
  output logic [CHK_W-1:0] checkWord,
  output logic [CHK_W-1:0] syndrome,
  output logic             done,
  output logic             ok
);
  strobe_t strb;

  cwchk_ctrl #(.MsgBits(MSG_BITS), .CodeBits(CODE_BITS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startClr (startClr),
    .modeCheck(modeCheck),
    .bitValid (bitValid),
    .strb     (strb),
    .done     (done)
  );

  cwchk_dp #(.RemW(REM_W), .Poly(GEN_POLY)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitIn    (bitIn),
    .checkWord(checkWord),
    .syndrome (syndrome),
    .ok       (ok)
  );
endmodule

// File: tb/tb_cwchk_top.sv
`timescale 1ns/1ps
module tb_cwchk_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startClr = 1'b0;
  logic        modeCheck = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [15:0] checkWord;
  logic [15:0] syndrome;
  logic        done;
  logic        ok;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  cwchk_top dut (.*);

  always #4 clk = ~clk;

  typedef struct packed { logic [47:0] msg; logic [6:0] flip; } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{48'h000000000000, 7'd0},
    '{48'hFFFFFFFFFFFF, 7'd0},
    '{48'h800000000000, 7'd1},
    '{48'h000000000001, 7'd48},
    '{48'hA5A5A5A5A5A5, 7'd63},
    '{48'h123456789ABC, 7'd64},
    '{48'hC0FFEE123456, 7'd49},
    '{48'h5A5A00FF0F0F, 7'd30}
  };

  function automatic logic [14:0] polyMod(input logic [77:0] v);
    logic [77:0] t;
    t = v;
    for (int i = 77; i >= 15; i--)
      if (t[i]) t[i -: 16] = t[i -: 16] ^ 16'hE815;
    return t[14:0];
  endfunction

  function automatic logic [15:0] genModel(input logic [47:0] msg);
    logic [14:0] r, c;
    r = polyMod({15'b0, msg, 15'b0});
    c = {r[14:1], ~r[0]};
    return {c, (^msg) ^ (^c)};
  endfunction

  function automatic logic [15:0] synModel(input logic [63:0] cw);
    logic [62:0] v;
    v = cw[63:1];
    v[0] = ~v[0];
    return {(^cw[63:1]) ^ cw[0], polyMod({v, 15'b0})};
  endfunction

  task automatic chk(input bit pass, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!pass) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cw[63] is codeword bit 1; returns at the negedge where done should be high
  task automatic runFrame(input logic mode, input logic [63:0] cw, input int n,
                          input bit gaps);
    @(negedge clk);
    startClr = 1'b1; modeCheck = mode; bitValid = 1'b0;
    @(negedge clk);
    startClr = 1'b0; modeCheck = ~mode;   // R9: toggled after latch
    for (int i = 0; i < n; i++) begin
      bitValid = 1'b1; bitIn = cw[63-i];
      @(negedge clk);
      if (gaps && (i % 5 == 2) && (i < n - 1)) begin
        bitValid = 1'b0; bitIn = ~bitIn;
        @(negedge clk);
      end
    end
    bitValid = 1'b0;
  endtask

  task automatic encodeAndCheck(input logic [47:0] msg, input int flip, input bit gaps);
    logic [15:0] cwExp, synExp;
    logic [63:0] cw;
    cwExp = genModel(msg);
    runFrame(1'b0, {msg, 16'h0}, 48, gaps);
    chk(done == 1'b1, "R6 done after 48th bit", 64'(done), 64'd1);
    chk(checkWord[15:1] == cwExp[15:1], "R1 remainder field", 64'(checkWord), 64'(cwExp));
    chk(checkWord[0] == cwExp[0], "R2 parity bit", 64'(checkWord[0]), 64'(cwExp[0]));
    chk(^{msg, checkWord} == 1'b0, "R2 even overall", 64'(^{msg, checkWord}), 64'd0);
    chk(syndrome == 16'h0 && ok == 1'b0, "R11 gen outputs", {syndrome, 15'b0, ok}, 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", 64'(done), 64'd0);
    cw = {msg, checkWord};
    if (flip != 0) cw[64-flip] = ~cw[64-flip];
    synExp = synModel(cw);
    runFrame(1'b1, cw, 64, gaps);
    chk(done == 1'b1, "R6 done after 64th bit", 64'(done), 64'd1);
    chk(syndrome == synExp, "R3 syndrome", 64'(syndrome), 64'(synExp));
    chk(ok == (synExp == 16'h0), "R4 ok flag", 64'(ok), 64'(synExp == 16'h0));
    if (flip == 0)
      chk(syndrome == 16'h0 && ok, "R4 clean codeword passes", {syndrome, ok}, 64'd1);
    else
      chk(syndrome != 16'h0 && !ok, "R5 single flip rejected", {syndrome, ok}, 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nFails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [47:0] m;
    logic [15:0] e, savedSyn;
    logic [63:0] cw;
    bit sawDone;

    repeat (3) @(negedge clk);
    chk(checkWord == 0 && syndrome == 0 && !ok && !done, "R10 reset state",
        {checkWord, syndrome, 15'b0, ok, done}, 64'd0);
    rstN = 1'b1;

    // R10: generate mode by default, no clear needed
    m = 48'h0F1E2D3C4B5A;
    e = genModel(m);
    for (int i = 0; i < 48; i++) begin
      bitValid = 1'b1; bitIn = m[47-i];
      @(negedge clk);
    end
    bitValid = 1'b0;
    chk(done && checkWord == e, "R10 default generate", 64'(checkWord), 64'(e));

    // table walk
    for (int k = 0; k < NV; k++)
      encodeAndCheck(VECS[k].msg, int'(VECS[k].flip), 1'b0);

    // random messages with gaps (R12)
    for (int k = 0; k < 16; k++) begin
      m = {$urandom, $urandom};
      encodeAndCheck(m, int'($urandom % 65), 1'b1);
    end
    m = 48'h3C3C3C3C3C3C;
    e = genModel(m);
    runFrame(1'b0, {m, 16'h0}, 48, 1'b1);
    chk(checkWord == e, "R12 gapped stream", 64'(checkWord), 64'(e));

    // every single-bit flip of one codeword (R5)
    m = 48'h9E3779B97F4A;
    e = genModel(m);
    for (int f = 1; f <= 64; f++) begin
      cw = {m, e};
      cw[64-f] = ~cw[64-f];
      runFrame(1'b1, cw, 64, 1'b0);
      chk(!ok && syndrome != 0, "R5 exhaustive flip", {syndrome, ok}, 64'd0);
    end

    // R8: extra bits after a finished check frame
    runFrame(1'b1, {m, e}, 64, 1'b0);
    savedSyn = syndrome;
    chk(ok == 1'b1, "R4 valid frame before extras", 64'(ok), 64'd1);
    sawDone = 0;
    for (int i = 0; i < 12; i++) begin
      bitValid = 1'b1; bitIn = i[0];
      @(negedge clk);
      if (done && i > 0) sawDone = 1;
    end
    bitValid = 1'b0;
    @(negedge clk);
    chk(!sawDone && !done, "R8 no done from extra bits", 64'(sawDone), 64'd0);
    chk(syndrome == savedSyn && ok, "R8 outputs unchanged", {syndrome, ok}, {savedSyn, 1'b1});

    // R7: clear zeroes outputs
    @(negedge clk); startClr = 1'b1; modeCheck = 1'b0;
    @(negedge clk); startClr = 1'b0;
    chk(checkWord == 0 && syndrome == 0 && !ok && !done, "R7 clear zeroes outputs",
        {checkWord, syndrome, 15'b0, ok, done}, 64'd0);

    // R7: abandon a frame, then clear with a simultaneous valid bit (dropped)
    for (int i = 0; i < 20; i++) begin
      bitValid = 1'b1; bitIn = 1'b1;
      @(negedge clk);
    end
    m = 48'h7E57C0DE0001;
    e = genModel(m);
    startClr = 1'b1; modeCheck = 1'b0; bitValid = 1'b1; bitIn = 1'b1;
    @(negedge clk);
    startClr = 1'b0;
    for (int i = 0; i < 48; i++) begin
      bitValid = 1'b1; bitIn = m[47-i];
      @(negedge clk);
    end
    bitValid = 1'b0;
    chk(done && checkWord == e, "R7 clear mid-frame and drop", 64'(checkWord), 64'(e));

    // R9: check mode latched, modeCheck low during frame
    runFrame(1'b1, {m, e}, 64, 1'b0);
    chk(done && ok && checkWord == 0, "R9 mode held through frame",
        {checkWord, ok, done}, {16'h0, 1'b1, 1'b1});

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule